// File: doc/BRIEF.md
# Command Word Collector

This block gives software a two-register way to issue commands to a controller. A write to the command port selects an operation. Each operation needs a fixed number of 32-bit argument words, and software supplies them one at a time through the data port. The block keeps a count of the words received and stores each one at the next position in an argument store. When the count reaches the amount the operation needs, the block raises a one-cycle dispatch pulse. The pulse carries the operation code, and the whole argument store is presented beside it.

An operation that needs no arguments is dispatched by the command write itself. A code outside the legal range selects an internal "unknown" slot. That slot completes at once with a failed status and is never dispatched. After a dispatch the block waits for the external handler to return a status word, marked by a done strobe. It then latches that word into the status register that software reads. The argument store is sized for the largest operation, the ring-setup descriptor, and its depth comes from the ring page count.

Top module: `cmd_collector`

## Requirements
- R1: After reset, `cmd_status_o` is 32'h0000_0000 (succeeded), and `busy_o` and `disp_o` are low.
- R2: While the block is not busy, a command write whose value is 0 or at least 10 sets the status to 32'hFFFF_FFFF (failed) on the next cycle and produces no dispatch.
- R3: While the block is not busy, a command write of a legal code (1 to 9) sets the status to 32'hFFFF_FFFE (not enough data) on the next cycle.
- R4: Codes 2, 3, 6 and 8 need no arguments. Their command write raises `disp_o` for exactly one cycle, starting on the cycle after the write, with `disp_code_o` equal to the code.
- R5: The other codes need this many words: code 1 needs 6, code 4 needs 4+4·RING_PAGES, code 5 needs 3, code 7 needs 2+2·MSG_PAGES, and code 9 needs 4. The dispatch comes on the cycle after the last required word and never earlier.
- R6: Argument word k, counted from 0 after the command write, appears at `disp_args_o[32*k +: 32]` while the dispatch is presented.
- R7: From the dispatch until the handler's done strobe, `busy_o` is high and the status stays "not enough data". On the cycle after `hnd_done_i`, the status equals `hnd_status_i` and `busy_o` is low.
- R8: Command and data writes made while `busy_o` is high are dropped. They cause no dispatch and no status change, and they do not affect the next command.
- R9: A command write made part-way through collecting arguments discards the words gathered so far. The new code then needs its full word count.
- R10: A data write with no command in progress sets the status to failed and produces no dispatch.
- R11: When a command write and a data write fall in the same cycle, the data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_val_i | input | 32 | Command code written |
| dat_wr_i | input | 1 | Data register write strobe |
| dat_val_i | input | 32 | Argument word written |
| disp_o | output | 1 | One-cycle dispatch pulse |
| disp_code_o | output | 4 | Code of the dispatched operation, held while busy |
| disp_args_o | output | 32·BUF_WORDS | Argument store; word k at bits 32k+31..32k |
| hnd_done_i | input | 1 | Handler has finished |
| hnd_status_i | input | 32 | Handler result, sampled with `hnd_done_i` |
| busy_o | output | 1 | A dispatched operation awaits its result |
| cmd_status_o | output | 32 | Command status register |

## Verification
The assertions assume that the handler raises `hnd_done_i` only while `busy_o` is high. They also assume the strobes are single-cycle pulses driven between clock edges. The stimulus follows this: it returns a result only after it has seen a dispatch, and it changes inputs only on the falling edge. It sweeps every legal code, several illegal values, writes made while busy, collection that is restarted part-way, and a command write and a data write in the same cycle. Each case is checked against word counts the bench computes from the page parameters.

// File: rtl/cmdc_pkg.sv
`timescale 1ns/1ps
package cmdc_pkg;
    localparam int CODE_W    = 4;
    localparam int CODE_LAST = 10;

    localparam logic [CODE_W-1:0] OP_NONE     = 4'd0;
    localparam logic [CODE_W-1:0] OP_CONFIG   = 4'd1;
    localparam logic [CODE_W-1:0] OP_ISSUE    = 4'd2;
    localparam logic [CODE_W-1:0] OP_UNPLUG   = 4'd3;
    localparam logic [CODE_W-1:0] OP_RINGS    = 4'd4;
    localparam logic [CODE_W-1:0] OP_RST_TGT  = 4'd5;
    localparam logic [CODE_W-1:0] OP_RST_BUS  = 4'd6;
    localparam logic [CODE_W-1:0] OP_MSG_RING = 4'd7;
    localparam logic [CODE_W-1:0] OP_RST_ALL  = 4'd8;
    localparam logic [CODE_W-1:0] OP_ABORT    = 4'd9;

    localparam logic [31:0] ST_OK   = 32'h0000_0000;
    localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;
    localparam logic [31:0] ST_NED  = 32'hFFFF_FFFE;

    localparam int CONFIG_WORDS = 6;
    localparam int RST_TGT_WORDS = 3;
    localparam int ABORT_WORDS  = 4;
endpackage

// File: rtl/cmdc_need_lut.sv
`timescale 1ns/1ps
module cmdc_need_lut #(
    parameter int RING_WORDS = 132,
    parameter int MSG_WORDS  = 34,
    parameter int CNT_W      = 8
) (
    input  logic [cmdc_pkg::CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]            need_o
);
    import cmdc_pkg::*;

    always_comb begin
        case (code_i)
            OP_CONFIG:   need_o = CNT_W'(CONFIG_WORDS);
            OP_RINGS:    need_o = CNT_W'(RING_WORDS);
            OP_RST_TGT:  need_o = CNT_W'(RST_TGT_WORDS);
            OP_MSG_RING: need_o = CNT_W'(MSG_WORDS);
            OP_ABORT:    need_o = CNT_W'(ABORT_WORDS);
            default:     need_o = '0;
        endcase
    end
endmodule

// File: rtl/cmdc_arg_store.sv
`timescale 1ns/1ps
module cmdc_arg_store #(
    parameter int DEPTH = 132,
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [31:0]           wdata_i,
    output logic [DEPTH*32-1:0]   flat_o
);
    localparam logic [IDX_W-1:0] DEPTH_LIM = IDX_W'(DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  word_q <= '0;
            else if (wr_en_i && idx_i == IDX_W'(g))      word_q <= wdata_i;
        end
        assign flat_o[32*g +: 32] = word_q;
    end

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (idx_i < DEPTH_LIM));
endmodule

// File: rtl/cmdc_seq.sv
`timescale 1ns/1ps
module cmdc_seq #(
    parameter int BUF_WORDS = 132,
    parameter int CNT_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_wr_i,
    input  logic [31:0]                 cmd_val_i,
    input  logic                        dat_wr_i,
    input  logic                        hnd_done_i,
    input  logic [31:0]                 hnd_status_i,
    input  logic [CNT_W-1:0]            need_i,
    output logic [cmdc_pkg::CODE_W-1:0] sel_code_o,
    output logic                        wr_en_o,
    output logic [CNT_W-1:0]            wr_idx_o,
    output logic                        disp_o,
    output logic [cmdc_pkg::CODE_W-1:0] disp_code_o,
    output logic                        busy_o,
    output logic [31:0]                 status_o
);
    import cmdc_pkg::*;

    localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_WORDS);

    typedef struct packed {
        logic [CODE_W-1:0] cur;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              disp;
        logic [CODE_W-1:0] dcode;
        logic [31:0]       status;
    } seq_t;

    seq_t s_q, s_d;

    logic              code_ok;
    logic [CODE_W-1:0] new_code;
    logic [CNT_W-1:0]  cnt_inc;

    assign code_ok    = (cmd_val_i != 32'd0) && (cmd_val_i < 32'(CODE_LAST));
    assign new_code   = code_ok ? cmd_val_i[CODE_W-1:0] : OP_NONE;
    assign sel_code_o = cmd_wr_i ? new_code : s_q.cur;
    assign cnt_inc    = s_q.cnt + 1'b1;
    assign wr_idx_o   = s_q.cnt;

    always_comb begin
        s_d      = s_q;
        s_d.disp = 1'b0;
        wr_en_o  = 1'b0;
        if (s_q.busy) begin
            if (hnd_done_i) begin
                s_d.busy   = 1'b0;
                s_d.status = hnd_status_i;
            end
        end else if (cmd_wr_i) begin
            s_d.cnt    = '0;
            s_d.status = ST_NED;
            s_d.cur    = new_code;
            if (!code_ok) begin
                s_d.status = ST_FAIL;
                s_d.cur    = OP_NONE;
            end else if (need_i == '0) begin
                s_d.disp  = 1'b1;
                s_d.busy  = 1'b1;
                s_d.dcode = new_code;
                s_d.cur   = OP_NONE;
            end
        end else if (dat_wr_i) begin
            if (s_q.cur == OP_NONE) begin
                s_d.status = ST_FAIL;
            end else if (s_q.cnt < BUF_LIM) begin
                wr_en_o = 1'b1;
                s_d.cnt = cnt_inc;
                if (cnt_inc >= need_i) begin
                    s_d.disp  = 1'b1;
                    s_d.busy  = 1'b1;
                    s_d.dcode = s_q.cur;
                    s_d.cur   = OP_NONE;
                    s_d.cnt   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.status <= ST_OK;
        end else begin
            s_q <= s_d;
        end
    end

    assign disp_o      = s_q.disp;
    assign disp_code_o = s_q.dcode;
    assign busy_o      = s_q.busy;
    assign status_o    = s_q.status;

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.disp |=> !s_q.disp);
    assert_disp_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.disp |-> (s_q.dcode != OP_NONE && s_q.dcode < CODE_W'(CODE_LAST)));
    assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && cmd_wr_i && (cmd_val_i == 32'd0 || cmd_val_i >= 32'(CODE_LAST)))
        |=> (s_q.status == ST_FAIL && !s_q.disp));
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> s_q.disp);
    assert_done_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && hnd_done_i) |=> (!s_q.busy && s_q.status == $past(hnd_status_i)));
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !hnd_done_i) |=> (s_q.busy && $stable(s_q.status) && !s_q.disp));
endmodule

// File: rtl/cmd_collector.sv
`timescale 1ns/1ps
module cmd_collector #(
    parameter int RING_PAGES = 32,
    parameter int MSG_PAGES  = 16,
    localparam int RING_WORDS = 4 + 4 * RING_PAGES,
    localparam int MSG_WORDS  = 2 + 2 * MSG_PAGES,
    localparam int BIG_WORDS  = (RING_WORDS > MSG_WORDS) ? RING_WORDS : MSG_WORDS,
    localparam int BUF_WORDS  = (BIG_WORDS > cmdc_pkg::CONFIG_WORDS) ? BIG_WORDS : cmdc_pkg::CONFIG_WORDS,
    localparam int CNT_W      = $clog2(BUF_WORDS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_wr_i,
    input  logic [31:0]                   cmd_val_i,
    input  logic                          dat_wr_i,
    input  logic [31:0]                   dat_val_i,
    output logic                          disp_o,
    output logic [cmdc_pkg::CODE_W-1:0]   disp_code_o,
    output logic [BUF_WORDS*32-1:0]       disp_args_o,
    input  logic                          hnd_done_i,
    input  logic [31:0]                   hnd_status_i,
    output logic                          busy_o,
    output logic [31:0]                   cmd_status_o
);
    logic [cmdc_pkg::CODE_W-1:0] sel_code;
    logic [CNT_W-1:0]            need;
    logic                        wr_en;
    logic [CNT_W-1:0]            wr_idx;

    cmdc_need_lut #(
        .RING_WORDS(RING_WORDS), .MSG_WORDS(MSG_WORDS), .CNT_W(CNT_W)
    ) u_lut (
        .code_i(sel_code), .need_o(need)
    );

    cmdc_seq #(.BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_i(cmd_wr_i), .cmd_val_i(cmd_val_i), .dat_wr_i(dat_wr_i),
        .hnd_done_i(hnd_done_i), .hnd_status_i(hnd_status_i),
        .need_i(need), .sel_code_o(sel_code),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .disp_o(disp_o), .disp_code_o(disp_code_o),
        .busy_o(busy_o), .status_o(cmd_status_o)
    );

    cmdc_arg_store #(.DEPTH(BUF_WORDS), .IDX_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(wr_idx),
        .wdata_i(dat_val_i), .flat_o(disp_args_o)
    );
endmodule

// File: tb/sim_cmd_collector.sv
`timescale 1ns/1ps
module sim_cmd_collector;
    localparam int RP = 32;
    localparam int MP = 16;
    localparam int BW = 4 + 4 * RP;
    localparam logic [31:0] OK = 32'h0, FAILV = 32'hFFFF_FFFF, NED = 32'hFFFF_FFFE;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0, dat_wr = 1'b0, hnd_done = 1'b0;
    logic [31:0] cmd_val = '0, dat_val = '0, hnd_status = '0;
    logic disp, busy;
    logic [3:0] disp_code;
    logic [BW*32-1:0] args;
    logic [31:0] status;

    int nchk = 0;
    int nfail = 0;

    cmd_collector #(.RING_PAGES(RP), .MSG_PAGES(MP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_i(cmd_wr), .cmd_val_i(cmd_val),
        .dat_wr_i(dat_wr), .dat_val_i(dat_val),
        .disp_o(disp), .disp_code_o(disp_code), .disp_args_o(args),
        .hnd_done_i(hnd_done), .hnd_status_i(hnd_status),
        .busy_o(busy), .cmd_status_o(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int words_of(input int c);
        case (c)
            1: return 6;
            4: return 4 + 4 * RP;
            5: return 3;
            7: return 2 + 2 * MP;
            9: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] pat(input int c, input int k);
        return {c[7:0], 8'hA5, k[15:0]};
    endfunction

    task automatic put_cmd(input logic [31:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_val = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic put_dat(input logic [31:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_val = v;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic give_done(input logic [31:0] v);
        @(negedge clk); hnd_done = 1'b1; hnd_status = v;
        @(negedge clk); hnd_done = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", status, OK);
        check("R1 busy", {31'b0, busy}, 32'h0);
        check("R1 disp", {31'b0, disp}, 32'h0);

        // R2: illegal codes
        foreach (cmd_val[i]) begin end
        for (int t = 0; t < 5; t++) begin
            logic [31:0] bad;
            case (t)
                0: bad = 32'd0;
                1: bad = 32'd10;
                2: bad = 32'd15;
                3: bad = 32'h0001_0004;
                default: bad = 32'hFFFF_FFFF;
            endcase
            give_reset_status();
            put_cmd(bad);
            check("R2 status", status, FAILV);
            check("R2 no disp", {31'b0, disp}, 32'h0);
        end

        // R3..R8: sweep all legal codes
        for (int c = 1; c < 10; c++) begin
            int n;
            n = words_of(c);
            put_cmd(c);
            if (n == 0) begin
                check("R4 disp", {31'b0, disp}, 32'h1);
                check("R4 code", {28'b0, disp_code}, c);
                @(negedge clk);
                check("R4 pulse width", {31'b0, disp}, 32'h0);
            end else begin
                check("R3 status", status, NED);
                check("R3 no disp", {31'b0, disp}, 32'h0);
                for (int k = 0; k < n; k++) begin
                    put_dat(pat(c, k));
                    if (k < n - 1) check("R5 early", {31'b0, disp}, 32'h0);
                end
                check("R5 disp", {31'b0, disp}, 32'h1);
                check("R5 code", {28'b0, disp_code}, c);
                for (int k = 0; k < n; k++)
                    check("R6 arg", args[32*k +: 32], pat(c, k));
                @(negedge clk);
                check("R5 pulse width", {31'b0, disp}, 32'h0);
            end
            check("R7 busy", {31'b0, busy}, 32'h1);
            check("R7 status held", status, NED);
            put_cmd(6);
            check("R8 cmd dropped", {31'b0, disp}, 32'h0);
            put_dat(32'hDEAD_0000);
            check("R8 status", status, NED);
            check("R8 busy", {31'b0, busy}, 32'h1);
            give_done(32'h0101_0101 * c);
            check("R7 result", status, 32'h0101_0101 * c);
            check("R7 idle", {31'b0, busy}, 32'h0);
        end

        // R8 follow-up: dropped writes left no trace; code 5 still needs 3 words
        put_cmd(5);
        put_dat(pat(5, 0));
        put_dat(pat(5, 1));
        check("R8 no leftover", {31'b0, disp}, 32'h0);
        put_dat(pat(5, 2));
        check("R8 disp after 3", {31'b0, disp}, 32'h1);
        give_done(OK);

        // R9: restart mid-collection
        put_cmd(1);
        for (int k = 0; k < 3; k++) put_dat(pat(1, k));
        put_cmd(9);
        check("R9 status", status, NED);
        for (int k = 0; k < 3; k++) begin
            put_dat(pat(9, k));
            check("R9 no early disp", {31'b0, disp}, 32'h0);
        end
        put_dat(pat(9, 3));
        check("R9 disp", {31'b0, disp}, 32'h1);
        check("R9 code", {28'b0, disp_code}, 32'd9);
        check("R9 arg0", args[31:0], pat(9, 0));
        give_done(OK);

        // R10: stray data word
        check("R10 pre", status, OK);
        put_dat(32'h1234_5678);
        check("R10 status", status, FAILV);
        check("R10 no disp", {31'b0, disp}, 32'h0);

        // R11: simultaneous command and data
        @(negedge clk); cmd_wr = 1'b1; cmd_val = 32'd5; dat_wr = 1'b1; dat_val = 32'hBAD0_BAD0;
        @(negedge clk); cmd_wr = 1'b0; dat_wr = 1'b0;
        check("R11 status", status, NED);
        put_dat(pat(11, 0));
        put_dat(pat(11, 1));
        check("R11 not counted", {31'b0, disp}, 32'h0);
        put_dat(pat(11, 2));
        check("R11 disp", {31'b0, disp}, 32'h1);
        check("R11 arg0", args[31:0], pat(11, 0));
        give_done(OK);

        repeat (2) @(negedge clk);
        finish_run();
    end

    // Brings the status to a known non-failed value before an R2 probe.
    task automatic give_reset_status;
        put_cmd(32'd6);
        give_done(32'h5555_0000);
    endtask
endmodule